// File: doc/BRIEF.md
# PC Card Host Bus Decoder

This block decodes a PC Card host bus into two on-card targets: a small byte-wide attribute memory and a UART register file. Every host access arrives on one bus. The attribute select combined with the memory read enable or write strobe reaches attribute memory. The same select combined with the I/O read or write strobe reaches the UART registers. Common memory space is never decoded. The block generates the I/O read acknowledge and a ready/busy-then-interrupt request toward the host. It also raises a flag toward the on-card subsystem each time the host writes attribute memory.

The card powers up unconfigured, and in that state it ignores I/O cycles. A nonzero byte written to the configuration option location in attribute memory enables I/O decoding. A zero written there disables it again. I/O registers are selected by the low three address bits. The mode input can instead require all ten address bits to hit a fixed port base. All strobes are sampled on a system clock. Each write is executed once, on the first sampled cycle of its strobe. Read data, the output enable and the acknowledge are registered, and all three become valid one clock after the strobe is first sampled. The UART is a stub register file: eight byte registers, with its interrupt line taken from bit 0 of register 1.

Top module: `pccard_bus_decoder`

## Requirements
- R1: While `rst` is high and after it: `inpack_n`=1, `dout_oe`=0, `sub_irq`=0, `ireq_n`=0, UART registers read as 0, and the card is unconfigured.
- R2: An I/O cycle is accepted only when `attr_n`=0, at least one bit of `ce_n` is 0, the I/O strobe is 0 and the card is configured. Otherwise no register strobe, acknowledge or data enable appears, and a write leaves the register unchanged.
- R3: An attribute access needs `attr_n`=0 and a card enable, with `oe_n`=0 to read or `we_n`=0 to write. The byte index is `addr[8:1]`, so `addr[0]` does not matter. Read data is on `dout` one clock after the strobe is sampled.
- R4: With `attr_n`=1, the memory strobes do nothing: no write, no `sub_irq`, no `dout_oe`.
- R5: In card mode (`legacy_port`=0), the UART register index is `addr[2:0]` and `addr[9:3]` is ignored.
- R6: In legacy mode (`legacy_port`=1), an I/O cycle is accepted only if `addr[9:3]` equals bits 9:3 of the port base 0x3F8. The index is still `addr[2:0]`.
- R7: `inpack_n` goes 0 one clock after an accepted I/O read is sampled. It returns to 1 one clock after the read strobe is released.
- R8: Writing a nonzero byte to attribute index 0x80 (host address 0x100 or 0x101) configures the card. Writing zero there unconfigures it.
- R9: `sub_irq` goes to 1 one clock after an attribute write is first sampled. A high `sub_clr` clears it on the next clock. A new write in the same cycle as a clear wins.
- R10: For `BUSY_CYCLES` clocks after reset release, `ireq_n` stays 0 (busy). After that, it is the inverse of the UART interrupt. A register write reaches `ireq_n` two clocks after the strobe is sampled.
- R11: `dout_oe` is 1 only on the clock after an accepted attribute read or accepted I/O read is sampled.
- R12: A write strobe held for many cycles causes exactly one one-clock `reg_wr_stb` or `attr_we` pulse, which carries the register index and write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 10 | Host address |
| din | input | 8 | Host write data |
| dout | output | 8 | Read data toward host |
| dout_oe | output | 1 | Read data bus drive enable |
| ce_n | input | 2 | Card enables, active low |
| attr_n | input | 1 | Attribute/I/O space select, active low |
| oe_n | input | 1 | Memory read enable, active low |
| we_n | input | 1 | Memory write strobe, active low |
| iord_n | input | 1 | I/O read strobe, active low |
| iowr_n | input | 1 | I/O write strobe, active low |
| legacy_port | input | 1 | 1 = full ten-bit port base compare |
| sub_clr | input | 1 | Subsystem clear for `sub_irq` |
| inpack_n | output | 1 | I/O read acknowledge, active low |
| ireq_n | output | 1 | Busy during power-up, then interrupt request, active low |
| sub_irq | output | 1 | Attribute-write flag to subsystem |
| reg_wr_stb | output | 1 | One-clock UART register write strobe |
| reg_rd_stb | output | 1 | One-clock UART register read strobe |
| reg_idx | output | 3 | UART register index |
| reg_wdata | output | 8 | UART register write data |
| attr_we | output | 1 | One-clock attribute memory write pulse |
| attr_re | output | 1 | Attribute memory read active |
| attr_idx | output | 8 | Attribute byte index |

## Verification
The bench writes UART registers before configuration and then reads them back. A design that skipped the configured check would return the written byte. It reads attribute bytes at the odd address of each pair, which catches a decoder that uses `addr[0]`. Memory strobes are issued with the attribute select high, which exposes a decoder that answers common memory. It drives high address bits outside the port base in both modes, which shows whether the compare is mode-dependent. Strobes are held for several clocks, so a level-triggered write would repeat the pulse. A clear is raised together with a new attribute write, so clear-over-set priority would drop the flag. The ready/busy window is counted cycle by cycle, which exposes an off-by-one in its length.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_ATTR = 2'd1,
    SRC_UART = 2'd2
  } rd_src_e;
endpackage

// File: rtl/pcd_decode.sv
module pcd_decode #(
  parameter int ADDR_W = 10,
  parameter int ATTR_AW = 8,
  parameter int REG_AW = 3,
  parameter int NUM_CE = 2,
  parameter logic [ADDR_W-1:0] LEGACY_BASE = 10'h3F8
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_CE-1:0]  ce_n,
  input  logic               attr_n,
  input  logic               oe_n,
  input  logic               we_n,
  input  logic               iord_n,
  input  logic               iowr_n,
  input  logic               legacy_port,
  input  logic               cfg_done,
  output logic               at_rd,
  output logic               at_wr,
  output logic               io_rd,
  output logic               io_wr,
  output logic [ATTR_AW-1:0] attr_idx,
  output logic [REG_AW-1:0]  reg_idx
);
  logic ce_any, space_sel, base_hit, io_ok;

  always_comb begin
    ce_any    = ~&ce_n;
    space_sel = ~attr_n & ce_any;
    base_hit  = addr[ADDR_W-1:REG_AW] == LEGACY_BASE[ADDR_W-1:REG_AW];
    io_ok     = space_sel & cfg_done & (legacy_port ? base_hit : 1'b1);
    at_rd     = space_sel & ~oe_n;
    at_wr     = space_sel & ~we_n;
    io_rd     = io_ok & ~iord_n;
    io_wr     = io_ok & ~iowr_n;
    attr_idx  = addr[ATTR_AW:1];
    reg_idx   = addr[REG_AW-1:0];
  end
endmodule

// File: rtl/pcd_attr_mem.sv
module pcd_attr_mem #(
  parameter int ATTR_AW = 8,
  parameter int DATA_W = 8,
  parameter logic [ATTR_AW-1:0] CFG_IDX = 8'h80
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [ATTR_AW-1:0] idx,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               cfg_done
);
  localparam int DEPTH = 1 << ATTR_AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    rdata <= mem[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_done <= 1'b0;
    else if (we && idx == CFG_IDX) cfg_done <= |wdata;
  end
endmodule

// File: rtl/pcd_uart_stub.sv
module pcd_uart_stub #(
  parameter int NREG = 8,
  parameter int DATA_W = 8,
  localparam int REG_AW = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [REG_AW-1:0] idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              intr
);
  logic [DATA_W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) regs[g] <= '0;
      else if (we && idx == REG_AW'(g)) regs[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else rdata <= regs[idx];
  end

  assign intr = regs[1][0];
endmodule

// File: rtl/pcd_ready_irq.sv
module pcd_ready_irq #(
  parameter int BUSY_CYCLES = 16,
  localparam int CW = $clog2(BUSY_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic uart_int,
  output logic ready,
  output logic ireq_n
);
  logic [CW-1:0] cnt;

  assign ready = cnt == CW'(BUSY_CYCLES);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      ireq_n <= 1'b0;
    end else begin
      if (!ready) cnt <= cnt + 1'b1;
      ireq_n <= ready ? ~uart_int : 1'b0;
    end
  end
endmodule

// File: rtl/pccard_bus_decoder.sv
module pccard_bus_decoder #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int ATTR_AW = 8,
  parameter int NREG = 8,
  parameter int NUM_CE = 2,
  parameter int BUSY_CYCLES = 16,
  parameter logic [ATTR_AW-1:0] CFG_IDX = 8'h80,
  parameter logic [ADDR_W-1:0] LEGACY_BASE = 10'h3F8,
  localparam int REG_AW = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  din,
  output logic [DATA_W-1:0]  dout,
  output logic               dout_oe,
  input  logic [NUM_CE-1:0]  ce_n,
  input  logic               attr_n,
  input  logic               oe_n,
  input  logic               we_n,
  input  logic               iord_n,
  input  logic               iowr_n,
  input  logic               legacy_port,
  input  logic               sub_clr,
  output logic               inpack_n,
  output logic               ireq_n,
  output logic               sub_irq,
  output logic               reg_wr_stb,
  output logic               reg_rd_stb,
  output logic [REG_AW-1:0]  reg_idx,
  output logic [DATA_W-1:0]  reg_wdata,
  output logic               attr_we,
  output logic               attr_re,
  output logic [ATTR_AW-1:0] attr_idx
);
  import pcd_pkg::*;

  logic at_rd, at_wr, io_rd, io_wr;
  logic [ATTR_AW-1:0] a_idx;
  logic [REG_AW-1:0]  r_idx;
  logic cfg_done, ready_w, uart_int;
  logic at_wr_prev, io_wr_prev, io_rd_prev;
  logic at_wr_edge, io_wr_edge, io_rd_edge;
  logic [DATA_W-1:0] mem_q, uart_q;
  rd_src_e src_q;

  pcd_decode #(
    .ADDR_W(ADDR_W), .ATTR_AW(ATTR_AW), .REG_AW(REG_AW),
    .NUM_CE(NUM_CE), .LEGACY_BASE(LEGACY_BASE)
  ) u_dec (
    .addr(addr), .ce_n(ce_n), .attr_n(attr_n), .oe_n(oe_n), .we_n(we_n),
    .iord_n(iord_n), .iowr_n(iowr_n), .legacy_port(legacy_port),
    .cfg_done(cfg_done), .at_rd(at_rd), .at_wr(at_wr), .io_rd(io_rd),
    .io_wr(io_wr), .attr_idx(a_idx), .reg_idx(r_idx)
  );

  assign at_wr_edge = at_wr & ~at_wr_prev;
  assign io_wr_edge = io_wr & ~io_wr_prev;
  assign io_rd_edge = io_rd & ~io_rd_prev;

  pcd_attr_mem #(
    .ATTR_AW(ATTR_AW), .DATA_W(DATA_W), .CFG_IDX(CFG_IDX)
  ) u_mem (
    .clk(clk), .rst(rst), .we(at_wr_edge), .idx(a_idx), .wdata(din),
    .rdata(mem_q), .cfg_done(cfg_done)
  );

  pcd_uart_stub #(.NREG(NREG), .DATA_W(DATA_W)) u_uart (
    .clk(clk), .rst(rst), .we(io_wr_edge), .idx(r_idx), .wdata(din),
    .rdata(uart_q), .intr(uart_int)
  );

  pcd_ready_irq #(.BUSY_CYCLES(BUSY_CYCLES)) u_rdy (
    .clk(clk), .rst(rst), .uart_int(uart_int), .ready(ready_w), .ireq_n(ireq_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      at_wr_prev <= 1'b0;
      io_wr_prev <= 1'b0;
      io_rd_prev <= 1'b0;
      src_q      <= SRC_NONE;
      dout_oe    <= 1'b0;
      inpack_n   <= 1'b1;
      sub_irq    <= 1'b0;
      reg_wr_stb <= 1'b0;
      reg_rd_stb <= 1'b0;
      reg_idx    <= '0;
      reg_wdata  <= '0;
      attr_we    <= 1'b0;
      attr_re    <= 1'b0;
      attr_idx   <= '0;
    end else begin
      at_wr_prev <= at_wr;
      io_wr_prev <= io_wr;
      io_rd_prev <= io_rd;
      src_q      <= at_rd ? SRC_ATTR : (io_rd ? SRC_UART : SRC_NONE);
      dout_oe    <= at_rd | io_rd;
      inpack_n   <= ~io_rd;
      if (at_wr_edge) sub_irq <= 1'b1;
      else if (sub_clr) sub_irq <= 1'b0;
      reg_wr_stb <= io_wr_edge;
      reg_rd_stb <= io_rd_edge;
      reg_idx    <= r_idx;
      reg_wdata  <= din;
      attr_we    <= at_wr_edge;
      attr_re    <= at_rd;
      attr_idx   <= a_idx;
    end
  end

  always_comb begin
    unique case (src_q)
      SRC_ATTR: dout = mem_q;
      SRC_UART: dout = uart_q;
      default:  dout = '0;
    endcase
  end
endmodule

// File: rtl/pcd_checker.sv
module pcd_checker #(
  parameter int NUM_CE = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CE-1:0] ce_n,
  input logic              attr_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              iord_n,
  input logic              inpack_n,
  input logic              dout_oe,
  input logic              sub_irq,
  input logic              reg_wr_stb,
  input logic              reg_rd_stb,
  input logic              attr_we,
  input logic              ireq_n,
  input logic              cfg_done,
  input logic              ready_w
);
  assert_ack_needs_io_read_R7: assert property (@(posedge clk) disable iff (rst)
    !inpack_n |-> $past(!iord_n && !attr_n && !(&ce_n) && cfg_done));

  assert_oe_needs_read_R11: assert property (@(posedge clk) disable iff (rst)
    dout_oe |-> $past(!attr_n && !(&ce_n) && (!oe_n || !iord_n)));

  assert_subirq_from_attr_write_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(sub_irq) |-> $past(!attr_n && !we_n && !(&ce_n)));

  assert_common_space_no_write_R4: assert property (@(posedge clk) disable iff (rst)
    attr_we |-> $past(!attr_n));

  assert_single_reg_write_R12: assert property (@(posedge clk) disable iff (rst)
    reg_wr_stb |=> !reg_wr_stb);

  assert_single_attr_write_R12: assert property (@(posedge clk) disable iff (rst)
    attr_we |=> !attr_we);

  assert_busy_holds_low_R10: assert property (@(posedge clk) disable iff (rst)
    !ready_w |-> !ireq_n);

  assert_unconfigured_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_stb || reg_rd_stb) |-> $past(cfg_done));
endmodule

bind pccard_bus_decoder pcd_checker #(.NUM_CE(NUM_CE)) u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .attr_n(attr_n), .oe_n(oe_n),
  .we_n(we_n), .iord_n(iord_n), .inpack_n(inpack_n), .dout_oe(dout_oe),
  .sub_irq(sub_irq), .reg_wr_stb(reg_wr_stb), .reg_rd_stb(reg_rd_stb),
  .attr_we(attr_we), .ireq_n(ireq_n), .cfg_done(cfg_done), .ready_w(ready_w)
);

// File: tb/pccard_bus_decoder_test.sv
module pccard_bus_decoder_test;
  localparam int BUSY = 16;

  logic       clk = 0;
  logic       rst = 1;
  logic [9:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       dout_oe;
  logic [1:0] ce_n = 2'b11;
  logic       attr_n = 1, oe_n = 1, we_n = 1, iord_n = 1, iowr_n = 1;
  logic       legacy_port = 0, sub_clr = 0;
  logic       inpack_n, ireq_n, sub_irq, reg_wr_stb, reg_rd_stb, attr_we, attr_re;
  logic [2:0] reg_idx;
  logic [7:0] reg_wdata, attr_idx;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pccard_bus_decoder #(.BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rst(rst), .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
    .ce_n(ce_n), .attr_n(attr_n), .oe_n(oe_n), .we_n(we_n), .iord_n(iord_n),
    .iowr_n(iowr_n), .legacy_port(legacy_port), .sub_clr(sub_clr),
    .inpack_n(inpack_n), .ireq_n(ireq_n), .sub_irq(sub_irq),
    .reg_wr_stb(reg_wr_stb), .reg_rd_stb(reg_rd_stb), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .attr_we(attr_we), .attr_re(attr_re), .attr_idx(attr_idx)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    attr_n = 1; oe_n = 1; we_n = 1; iord_n = 1; iowr_n = 1; ce_n = 2'b11;
  endtask

  task automatic attr_wr(input logic [9:0] a, input logic [7:0] d);
    addr = a; din = d; attr_n = 0; ce_n = 2'b10; we_n = 0;
    cyc(); cyc(); idle(); cyc();
  endtask

  task automatic attr_rd(input logic [9:0] a, output logic [7:0] d, output logic oe);
    addr = a; attr_n = 0; ce_n = 2'b10; oe_n = 0;
    cyc(); d = dout; oe = dout_oe;
    idle(); cyc();
  endtask

  task automatic io_wr(input logic [9:0] a, input logic [7:0] d);
    addr = a; din = d; attr_n = 0; ce_n = 2'b10; iowr_n = 0;
    cyc(); cyc(); idle(); cyc();
  endtask

  task automatic io_rd(input logic [9:0] a, input logic [1:0] ce,
                       output logic [7:0] d, output logic ack, output logic ack_after);
    addr = a; attr_n = 0; ce_n = ce; iord_n = 0;
    cyc(); d = dout; ack = inpack_n;
    idle(); cyc(); ack_after = inpack_n;
  endtask

  task automatic t_reset();
    repeat (3) cyc();
    chk(inpack_n == 1, "R1 inpack_n", inpack_n, 1);
    chk(dout_oe == 0, "R1 dout_oe", dout_oe, 0);
    chk(sub_irq == 0, "R1 sub_irq", sub_irq, 0);
    chk(ireq_n == 0, "R1 ireq_n", ireq_n, 0);
  endtask

  task automatic t_busy();
    bit low_ok = 1;
    rst = 0;
    for (int i = 0; i < BUSY; i++) begin
      cyc();
      if (ireq_n !== 0) low_ok = 0;
    end
    chk(low_ok, "R10 busy window low", low_ok, 1);
    cyc();
    chk(ireq_n == 1, "R10 ready after window", ireq_n, 1);
  endtask

  task automatic t_unconfigured();
    logic [7:0] d; logic a, aa;
    io_wr(10'h003, 8'h55);
    io_rd(10'h003, 2'b10, d, a, aa);
    chk(a == 1, "R2 no ack unconfigured", a, 1);
    attr_wr(10'h100, 8'h41);
    io_rd(10'h003, 2'b10, d, a, aa);
    chk(a == 0, "R8 ack after configure", a, 0);
    chk(d == 8'h00, "R2 write ignored while unconfigured", d, 8'h00);
  endtask

  task automatic t_attr();
    logic [7:0] d; logic oe;
    attr_rd(10'h101, d, oe);
    chk(d == 8'h41, "R3 config byte via odd address", d, 8'h41);
    chk(oe == 1, "R11 oe on attr read", oe, 1);
    attr_wr(10'h00A, 8'h3C);
    attr_rd(10'h00B, d, oe);
    chk(d == 8'h3C, "R3 addr0 ignored", d, 8'h3C);
  endtask

  task automatic t_subirq();
    chk(sub_irq == 1, "R9 set by attr write", sub_irq, 1);
    sub_clr = 1; cyc(); sub_clr = 0;
    chk(sub_irq == 0, "R9 cleared", sub_irq, 0);
    addr = 10'h010; din = 8'h99; attr_n = 0; ce_n = 2'b01; we_n = 0; sub_clr = 1;
    cyc();
    chk(sub_irq == 1, "R9 set wins over clear", sub_irq, 1);
    chk(attr_we == 1 && attr_idx == 8'h08, "R12 attr_we pulse idx", attr_idx, 8'h08);
    cyc();
    chk(attr_we == 0, "R12 attr_we single", attr_we, 0);
    sub_clr = 0; idle(); cyc();
  endtask

  task automatic t_common();
    logic [7:0] d; logic oe;
    addr = 10'h00A; din = 8'hFF; attr_n = 1; ce_n = 2'b10; we_n = 0;
    cyc(); cyc();
    chk(sub_irq == 0, "R4 no flag in common space", sub_irq, 0);
    we_n = 1; oe_n = 0; cyc();
    chk(dout_oe == 0, "R4 no oe in common space", dout_oe, 0);
    idle(); cyc();
    attr_rd(10'h00A, d, oe);
    chk(d == 8'h3C, "R4 attr byte unchanged", d, 8'h3C);
  endtask

  task automatic t_card_mode();
    logic [7:0] d; logic a, aa;
    io_wr(10'h003, 8'hA5);
    io_rd(10'h2F3, 2'b10, d, a, aa);
    chk(d == 8'hA5, "R5 high bits ignored", d, 8'hA5);
    chk(a == 0, "R7 ack during read", a, 0);
    chk(aa == 1, "R7 ack released", aa, 1);
    io_rd(10'h003, 2'b11, d, a, aa);
    chk(a == 1, "R2 no card enable no ack", a, 1);
    io_rd(10'h003, 2'b01, d, a, aa);
    chk(a == 0 && d == 8'hA5, "R2 either card enable", d, 8'hA5);
  endtask

  task automatic t_legacy();
    logic [7:0] d; logic a, aa;
    legacy_port = 1;
    io_rd(10'h003, 2'b10, d, a, aa);
    chk(a == 1, "R6 miss outside base", a, 1);
    io_wr(10'h2FB, 8'h11);
    io_rd(10'h3FB, 2'b10, d, a, aa);
    chk(a == 0, "R6 hit at base", a, 0);
    chk(d == 8'hA5, "R6 miss write ignored", d, 8'hA5);
    legacy_port = 0;
  endtask

  task automatic t_irq();
    addr = 10'h001; din = 8'h01; attr_n = 0; ce_n = 2'b10; iowr_n = 0;
    cyc();
    chk(ireq_n == 1, "R10 not yet low", ireq_n, 1);
    cyc();
    chk(ireq_n == 0, "R10 irq follows uart", ireq_n, 0);
    idle(); cyc();
    io_wr(10'h001, 8'h00);
    chk(ireq_n == 1, "R10 irq released", ireq_n, 1);
  endtask

  task automatic t_single_write();
    int pulses = 0;
    bit fields_ok = 1;
    addr = 10'h004; din = 8'h77; attr_n = 0; ce_n = 2'b10; iowr_n = 0;
    for (int i = 0; i < 6; i++) begin
      cyc();
      if (reg_wr_stb) begin
        pulses++;
        if (reg_idx != 3'd4 || reg_wdata != 8'h77) fields_ok = 0;
      end
      if (dout_oe) fields_ok = 0;
    end
    idle(); cyc();
    chk(pulses == 1, "R12 one write pulse", pulses, 1);
    chk(fields_ok, "R12 R11 pulse fields and no oe", fields_ok, 1);
  endtask

  task automatic t_unconfig_again();
    logic [7:0] d; logic a, aa;
    attr_wr(10'h100, 8'h00);
    io_rd(10'h004, 2'b10, d, a, aa);
    chk(a == 1, "R8 zero unconfigures", a, 1);
    chk(dout_oe == 0, "R11 no oe when idle", dout_oe, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_busy();
    t_unconfigured();
    t_attr();
    t_subirq();
    t_common();
    t_card_mode();
    t_legacy();
    t_irq();
    t_single_write();
    t_unconfig_again();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule